// File: doc/BRIEF.md
# Receive DMA Channel with Descriptor Ring

This channel carries a byte stream from a receiving peripheral into buffers in external memory. The buffers are described by a ring of 16-byte descriptors that sit back to back in memory. Each descriptor holds a buffer address in word 0, a byte length in bits 15:0 of word 1, and a control/status word in word 3. The channel reads a descriptor and packs arriving bytes little-endian into 32-bit single-beat writes. It then writes back the real byte count and a status word. After that it moves to the next descriptor, or returns to the ring base when the descriptor asks for a wrap.

A buffer closes normally when its byte count reaches the programmed length. It closes early when the peripheral marks a byte with a close flag and a status code. On an early close the channel records the true count, sets the Last flag and stores the peripheral's code. Ownership is passed with a Full flag. Software hands out a descriptor with Full clear, and the channel sets Full on write-back. If the channel fetches a descriptor that is still Full, it waits until software pulses a restart.

Both data paths use valid/ready. The memory master holds its request, address, data and strobes unchanged until the memory raises ready, and only one beat is outstanding. On the receive side a byte moves on a clock edge where valid and ready are both high. The source may hold valid for as long as it likes. The channel lowers ready while it fetches a descriptor, writes a data word, writes back a descriptor, or stalls.

Top module: `rxdma_ring_chan`

## Requirements
- R1: Once enabled, the channel reads each descriptor in three read beats, in this order: descriptor address +0, +4 and +12.
- R2: If the fetched word at +12 has bit 12 (Full) set, the channel stalls. During the stall it accepts no byte and issues no memory request. A restart pulse makes it fetch the same descriptor again.
- R3: Bytes are packed little-endian: the first byte of a word goes to bits 7:0. Words are written at the buffer address plus 4 times the word index. The buffer address is treated as word aligned.
- R4: Every data write enables only the lanes that carry received bytes: 4'hF for a full word, and the low n lanes (4'h1, 4'h3, 4'h7) for a final word that holds n bytes.
- R5: A buffer closes normally once the byte count equals the length in word 1 bits 15:0. Bits 31:16 of word 1 do not affect this. Word 1 is then written back as the length, with bits 31:16 set to zero.
- R6: A byte that arrives with the close flag is the last byte stored in its buffer. On such a close, word 1 is written back with the actual byte count.
- R7: If a close flag arrives on the byte that also reaches the length, the buffer is treated as an early close.
- R8: The word written back at +12 keeps bits 15 (Wrap) and 14 (Interrupt) as fetched and sets bit 12 (Full). Bit 13 (Last) is 1 only for an early close. Bits 11:0 hold the peripheral status code on an early close and zero otherwise. Bits 31:16 are zero.
- R9: After the write-back of a normal close whose bit 14 is set, `irq` is high for exactly one cycle. An early close raises no interrupt.
- R10: The next descriptor is at the current address +16. When bit 15 is set, the next descriptor is at the ring base instead.
- R11: A pending memory request keeps its address, direction and data until ready. `rx_ready` is never high while a memory request is pending.
- R12: With `cfg_en` low, the channel goes idle at the next descriptor boundary or on a restart, and it makes no memory request. Raising `cfg_en` from idle starts a fetch at the ring base.
- R13: A descriptor of length 0 is written back at once, with count 0, as a normal close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_restart | input | 1 | One-cycle pulse that leaves a Full stall |
| cfg_base | input | ADDR_W | Ring base address (16-byte aligned) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte lane strobes |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory accepts or completes the beat |
| rx_valid | input | 1 | Byte valid from the peripheral |
| rx_ready | output | 1 | Channel takes a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_close | input | 1 | This byte closes the buffer early |
| rx_status | input | 12 | Peripheral status code sent with rx_close |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench runs directed rings and then seeded random rings over a three-descriptor ring, against a memory model whose ready is random.

Packets that end on a word boundary and packets that end part way through a word show whether the lane strobes are correct. Packets that end by length, by an early close, or by a close on the final byte show whether the Last flag, the status field and the interrupt are decided correctly.

Zero-length descriptors, junk in the upper half of the length word, and the Full stall with the receive stream held valid check R13, R5 and R2. A disable-and-restart pass checks that the channel stays idle and then resumes at the ring base.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  // descriptor geometry and word offsets
  localparam int DESC_BYTES = 16;
  localparam int OFS_BUF    = 0;
  localparam int OFS_LEN    = 4;
  localparam int OFS_CTL    = 12;
  // control/status bit positions inside word 3
  localparam int BIT_WRAP   = 15;
  localparam int BIT_IRQ    = 14;
  localparam int BIT_LAST   = 13;
  localparam int BIT_FULL   = 12;
  localparam int STAT_W     = 12;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_BUF,
    ST_RD_LEN,
    ST_RD_CTL,
    ST_STALL,
    ST_FILL,
    ST_WR_DATA,
    ST_WB_LEN,
    ST_WB_CTL,
    ST_NEXT
  } chan_state_e;
endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int NLANE  = 4,
  parameter int LANE_W = $clog2(NLANE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [7:0]         din,
  input  logic               clear,
  output logic [8*NLANE-1:0] word,
  output logic [NLANE-1:0]   be,
  output logic [LANE_W-1:0]  fill
);
  // fill = number of bytes already held in the word under assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (clear)  fill <= '0;
    else if (push)   fill <= fill + 1'b1;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               word[8*g +: 8] <= '0;
      else if (push && fill == LANE_W'(g))      word[8*g +: 8] <= din;
    end
    assign be[g] = (fill > LANE_W'(g));
  end

  AST_PACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> fill < LANE_W'(NLANE)); // R3
endmodule

// File: rtl/rxdma_desc_ctrl.sv
module rxdma_desc_ctrl import rxdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int NLANE  = DATA_W / 8,
  parameter int LANE_W = $clog2(NLANE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_restart,
  input  logic [ADDR_W-1:0]  cfg_base,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [NLANE-1:0]   mem_be,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ready,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic               rx_close,
  input  logic [STAT_W-1:0]  rx_status,
  output logic               irq,
  output logic               pack_push,
  output logic               pack_clear,
  input  logic [DATA_W-1:0]  pack_word,
  input  logic [NLANE-1:0]   pack_be,
  input  logic [LANE_W-1:0]  pack_fill
);
  localparam logic [ADDR_W-1:0] STEP_DESC = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(NLANE);

  chan_state_e       state;
  logic [ADDR_W-1:0] cur_ptr, buf_ptr, base_al;
  logic [LEN_W-1:0]  len_r, cnt_r, cnt_nxt;
  logic [STAT_W-1:0] stat_r;
  logic              wrap_r, irqen_r, early_r, done_r, irq_r;
  logic              hit_len, closing, lane_full;
  logic [DATA_W-1:0] len_word, ctl_word;

  assign base_al   = {cfg_base[ADDR_W-1:4], 4'h0};
  assign cnt_nxt   = cnt_r + 1'b1;
  assign hit_len   = (cnt_nxt == len_r);
  assign closing   = rx_close | hit_len;
  assign lane_full = (pack_fill == LANE_W'(NLANE - 1));
  assign irq       = irq_r;

  always_comb begin
    len_word = '0;
    len_word[LEN_W-1:0] = cnt_r;
    ctl_word = '0;
    ctl_word[BIT_WRAP]     = wrap_r;
    ctl_word[BIT_IRQ]      = irqen_r;
    ctl_word[BIT_LAST]     = early_r;
    ctl_word[BIT_FULL]     = 1'b1;
    ctl_word[STAT_W-1:0]   = stat_r;
  end

  // memory and stream handshake decode
  always_comb begin
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_ptr;
    mem_wdata  = '0;
    mem_be     = '1;
    rx_ready   = 1'b0;
    pack_push  = 1'b0;
    pack_clear = 1'b0;
    unique case (state)
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(OFS_BUF);
      end
      ST_RD_LEN: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(OFS_LEN);
      end
      ST_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(OFS_CTL);
      end
      ST_FILL: begin
        rx_ready  = 1'b1;
        pack_push = rx_valid;
      end
      ST_WR_DATA: begin
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        mem_addr   = buf_ptr;
        mem_wdata  = pack_word;
        mem_be     = pack_be;
        pack_clear = mem_ready;
      end
      ST_WB_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + ADDR_W'(OFS_LEN);
        mem_wdata = len_word;
      end
      ST_WB_CTL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + ADDR_W'(OFS_CTL);
        mem_wdata = ctl_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_ptr <= '0;
      buf_ptr <= '0;
      len_r   <= '0;
      cnt_r   <= '0;
      stat_r  <= '0;
      wrap_r  <= 1'b0;
      irqen_r <= 1'b0;
      early_r <= 1'b0;
      done_r  <= 1'b0;
      irq_r   <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      unique case (state)
        ST_IDLE: if (cfg_en) begin
          cur_ptr <= base_al;
          state   <= ST_RD_BUF;
        end
        ST_RD_BUF: if (mem_ready) begin
          buf_ptr <= {mem_rdata[ADDR_W-1:2], 2'b00};
          state   <= ST_RD_LEN;
        end
        ST_RD_LEN: if (mem_ready) begin
          len_r <= mem_rdata[LEN_W-1:0];
          state <= ST_RD_CTL;
        end
        ST_RD_CTL: if (mem_ready) begin
          wrap_r  <= mem_rdata[BIT_WRAP];
          irqen_r <= mem_rdata[BIT_IRQ];
          cnt_r   <= '0;
          stat_r  <= '0;
          early_r <= 1'b0;
          done_r  <= 1'b0;
          if (mem_rdata[BIT_FULL])  state <= ST_STALL;
          else if (len_r == '0)     state <= ST_WB_LEN;
          else                      state <= ST_FILL;
        end
        ST_STALL: if (cfg_restart) state <= cfg_en ? ST_RD_BUF : ST_IDLE;
        ST_FILL: if (rx_valid) begin
          cnt_r <= cnt_nxt;
          if (closing) begin
            done_r  <= 1'b1;
            early_r <= rx_close;
            stat_r  <= rx_close ? rx_status : '0;
          end
          if (closing || lane_full) state <= ST_WR_DATA;
        end
        ST_WR_DATA: if (mem_ready) begin
          buf_ptr <= buf_ptr + STEP_WORD;
          state   <= done_r ? ST_WB_LEN : ST_FILL;
        end
        ST_WB_LEN: if (mem_ready) state <= ST_WB_CTL;
        ST_WB_CTL: if (mem_ready) begin
          irq_r <= irqen_r & ~early_r;
          state <= ST_NEXT;
        end
        ST_NEXT: begin
          cur_ptr <= wrap_r ? base_al : cur_ptr + STEP_DESC;
          state   <= cfg_en ? ST_RD_BUF : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_STALL |-> !rx_ready && !mem_req); // R2
  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != '0 && (NLANE'(mem_be + 1'b1) & mem_be) == '0); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FILL |-> cnt_r < len_r); // R5
endmodule

// File: rtl/rxdma_ring_chan.sv
module rxdma_ring_chan import rxdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_restart,
  input  logic [ADDR_W-1:0]     cfg_base,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  mem_ready,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [7:0]            rx_data,
  input  logic                  rx_close,
  input  logic [STAT_W-1:0]     rx_status,
  output logic                  irq
);
  localparam int NLANE  = DATA_W / 8;
  localparam int LANE_W = $clog2(NLANE + 1);

  logic              pack_push, pack_clear;
  logic [DATA_W-1:0] pack_word;
  logic [NLANE-1:0]  pack_be;
  logic [LANE_W-1:0] pack_fill;

  rxdma_packer #(.NLANE(NLANE), .LANE_W(LANE_W)) packer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (pack_push),
    .din   (rx_data),
    .clear (pack_clear),
    .word  (pack_word),
    .be    (pack_be),
    .fill  (pack_fill)
  );

  rxdma_desc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .NLANE(NLANE), .LANE_W(LANE_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_restart (cfg_restart),
    .cfg_base    (cfg_base),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_rdata   (mem_rdata),
    .mem_ready   (mem_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_close    (rx_close),
    .rx_status   (rx_status),
    .irq         (irq),
    .pack_push   (pack_push),
    .pack_clear  (pack_clear),
    .pack_word   (pack_word),
    .pack_be     (pack_be),
    .pack_fill   (pack_fill)
  );
endmodule

// File: tb/rxdma_ring_chan_tb_top.sv
`timescale 1ns/1ps
module rxdma_ring_chan_tb_top;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_restart = 1'b0;
  logic [31:0] cfg_base = BASE;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        rx_valid = 1'b0, rx_ready, rx_close = 1'b0, irq;
  logic [7:0]  rx_data = '0;
  logic [11:0] rx_status = '0;

  always #2.5 clk = ~clk;

  rxdma_ring_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_restart(cfg_restart), .cfg_base(cfg_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_close(rx_close),
    .rx_status(rx_status), .irq(irq)
  );

  // memory model with random ready
  logic [31:0] mem [0:1023];
  int          irq_cnt = 0, req_cnt = 0, viol_cnt = 0, rd_n = 0;
  logic [31:0] rd_log [0:15];
  logic [31:0] last_rd = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(negedge clk) begin
    mem_ready <= mem_req && ($urandom % 4 != 0);
    mem_rdata <= mem[mem_addr[11:2]];
  end

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (rst_n && rx_ready && mem_req) viol_cnt <= viol_cnt + 1;
    if (pend && (!mem_req || mem_addr != pend_addr)) viol_cnt <= viol_cnt + 1;
    pend <= mem_req && !mem_ready;
    pend_addr <= mem_addr;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        last_rd <= mem_addr;
        if (rd_n < 16) begin rd_log[rd_n] <= mem_addr; rd_n <= rd_n + 1; end
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] buf_of(int i);
    return 32'h400 + 32'h80 * i;
  endfunction

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  // per-descriptor plan: mode 0 = by length, 1 = early close, 2 = close on last byte
  int          d_len [0:2];
  int          d_mode[0:2];
  int          d_k   [0:2];
  bit          d_irq [0:2];
  logic [11:0] d_stat[0:2];
  logic [7:0]  sent  [0:63];

  task automatic load_ring(input bit full);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] d = (BASE + 32'(16 * i)) >> 2;
      mem[d]     = buf_of(i);
      mem[d + 1] = {16'($urandom), 16'(d_len[i])};
      mem[d + 2] = 32'h0;
      mem[d + 3] = {16'h0, (i == 2), d_irq[i], 1'b0, full, 12'h0};
      for (int w = 0; w < 32; w++) mem[(buf_of(i) >> 2) + w] = 32'hEEEE_EEEE;
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk) cfg_restart = 1'b1;
    @(negedge clk) cfg_restart = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit cl, input logic [11:0] st);
    bit ok;
    repeat ($urandom % 3) @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_close = cl; rx_status = st;
    forever begin
      ok = rx_ready;
      @(negedge clk);
      if (ok) break;
    end
    rx_valid = 1'b0; rx_close = 1'b0;
  endtask

  task automatic wait_wb(input logic [31:0] dw, output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (mem[dw + 3][12]) begin seen = 1'b1; break; end
    end
  endtask

  task automatic do_packet(input int i);
    int nb, icnt0;
    bit early, seen, dat_ok, tail_ok;
    logic [31:0] dw, exp_ctl;
    string rq;
    dw = (BASE + 32'(16 * i)) >> 2;
    nb = (d_mode[i] == 1) ? d_k[i] : d_len[i];
    early = (d_mode[i] != 0);
    icnt0 = irq_cnt;
    for (int j = 0; j < nb; j++) begin
      sent[j] = 8'($urandom);
      send_byte(sent[j], early && (j == nb - 1), d_stat[i]);
    end
    wait_wb(dw, seen);
    chk(seen, "R10", "descriptor written back", {31'd0, seen}, 32'd1);
    repeat (4) @(negedge clk);
    dat_ok = 1'b1; tail_ok = 1'b1;
    for (int j = 0; j < nb; j++) if (rd_byte(buf_of(i) + 32'(j)) != sent[j]) dat_ok = 1'b0;
    for (int j = nb; j < nb + 4; j++) if (rd_byte(buf_of(i) + 32'(j)) != 8'hEE) tail_ok = 1'b0;
    chk(dat_ok, "R3", "packed bytes in buffer", 32'(nb), 32'(nb));
    chk(tail_ok, "R4", "bytes past count untouched", rd_byte(buf_of(i) + 32'(nb)), 32'hEE);
    rq = (d_len[i] == 0) ? "R13" : (early ? "R6" : "R5");
    chk(mem[dw + 1] == 32'(nb), rq, "written-back length", mem[dw + 1], 32'(nb));
    exp_ctl = {16'h0, (i == 2), d_irq[i], early, 1'b1, early ? d_stat[i] : 12'h0};
    rq = (d_mode[i] == 2) ? "R7" : "R8";
    chk(mem[dw + 3] == exp_ctl, rq, "written-back control", mem[dw + 3], exp_ctl);
    chk((irq_cnt - icnt0) == int'(d_irq[i] && !early), "R9", "irq pulses",
        32'(irq_cnt - icnt0), 32'(d_irq[i] && !early));
  endtask

  task automatic run_round();
    load_ring(1'b0);
    pulse_restart();
    for (int i = 0; i < 3; i++) do_packet(i);
    repeat (40) @(negedge clk);
    chk(last_rd == BASE + 32'd12, "R10", "wrap refetch of ring base", last_rd, BASE + 32'd12);
  endtask

  task automatic rand_plan();
    for (int i = 0; i < 3; i++) begin
      d_len[i]  = $urandom % 21;
      d_mode[i] = $urandom % 3;
      if (d_len[i] == 0) d_mode[i] = 0;
      if (d_mode[i] == 1 && d_len[i] < 2) d_mode[i] = 0;
      d_k[i]    = (d_mode[i] == 1) ? 1 + ($urandom % (d_len[i] - 1)) : 0;
      d_irq[i]  = 1'($urandom);
      d_stat[i] = 12'($urandom) | 12'h1;
    end
  endtask

  initial begin
    int r0;
    bit saw_ready;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !rx_ready && !irq, "R12", "reset/idle outputs quiet",
        {29'd0, mem_req, rx_ready, irq}, 32'd0);

    // directed: start on a ring whose descriptors are still owned (Full)
    d_len  = '{6, 10, 5};  d_mode = '{0, 1, 2};  d_k = '{0, 3, 0};
    d_irq  = '{1, 1, 1};   d_stat = '{12'h0, 12'h5A1, 12'h7F3};
    load_ring(1'b1);
    cfg_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(rd_n >= 3 && rd_log[0] == BASE && rd_log[1] == BASE + 4 && rd_log[2] == BASE + 12,
        "R1", "fetch order", rd_log[2], BASE + 12);
    r0 = req_cnt; saw_ready = 1'b0;
    rx_valid = 1'b1; rx_data = 8'hA5;
    for (int t = 0; t < 60; t++) begin @(negedge clk); if (rx_ready) saw_ready = 1'b1; end
    rx_valid = 1'b0;
    chk(!saw_ready && req_cnt == r0, "R2", "stall on Full descriptor",
        32'(req_cnt - r0), 32'd0);
    run_round();

    // directed: zero length, aligned length, early close on first byte
    d_len  = '{0, 4, 7};  d_mode = '{0, 0, 1};  d_k = '{0, 0, 1};
    d_irq  = '{1, 0, 1};  d_stat = '{12'h0, 12'h0, 12'hFFF};
    run_round();

    for (int r = 0; r < 25; r++) begin
      rand_plan();
      run_round();
    end

    // disable: restart while enable low leaves the channel idle
    d_len = '{2, 3, 3}; d_mode = '{0, 0, 0}; d_irq = '{1, 0, 0};
    load_ring(1'b0);
    cfg_en = 1'b0;
    pulse_restart();
    repeat (4) @(negedge clk);
    r0 = req_cnt;
    repeat (100) @(negedge clk);
    chk(req_cnt == r0 && !rx_ready, "R12", "no requests while disabled",
        32'(req_cnt - r0), 32'd0);
    cfg_en = 1'b1;
    do_packet(0);
    chk(viol_cnt == 0, "R11", "handshake hold and ready exclusion", 32'(viol_cnt), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule